// File: doc/BRIEF.md
# Firmware-Space Address Window Remapper

This block sits between a host firmware-space request source and an on-chip system bus. Each incoming request carries a 32-bit address, an access size (one byte or one 32-bit word), a write flag and write data. The block decides whether the request lands inside a single programmable window. If it does, the block rebuilds the upper half of the address and issues one single-beat bus request. If it does not, the request is answered at once and never reaches the bus.

Two 32-bit configuration registers control the window and are written through a small write-only register port. The first register (select 0) packs the substitution base in bits [31:16] and the match value in bits [15:0]. The second register (select 1) packs the substitution mask in bits [31:16] and the per-bit ignore mask for matching in bits [15:0]. Only address bits [31:16] take part in matching and substitution. Bits [15:0] always reach the bus unchanged.

Requests use a valid/ready handshake, and only one request can be in flight at a time. A forwarded request holds `bus_valid` until the bus raises `bus_done`. The response (`rsp_valid`, data and two fault flags) is a one-cycle pulse.

Top module: `lpc_fw_remap`

## Requirements
- R1: After reset both configuration registers are zero. `req_ready` is 1 and `bus_valid` and `rsp_valid` are 0. With zero configuration, only requests whose address bits [31:16] equal 0x0000 hit, and they are forwarded with the address unchanged.
- R2: A request hits the window when every address bit [16+i] whose ignore-mask bit i (select 1, bits [15:0]) is 0 equals match bit i (select 0, bits [15:0]). Bits whose ignore-mask bit is 1 do not affect the decision.
- R3: For a hit, bus address bit [16+i] is substitution base bit i (select 0, bits [31:16]) where substitution mask bit i (select 1, bits [31:16]) is 1. Where that mask bit is 0, it is the incoming address bit [16+i].
- R4: Bus address bits [15:0] equal the incoming address bits [15:0].
- R5: A request that misses the window is not forwarded. In the cycle after acceptance, `rsp_valid` pulses with `rsp_miss`=1 and `rsp_rdata` all ones.
- R6: `req_size` 0 is a byte access and 1 is a word access. Both are forwarded on a hit, together with `req_write` and `req_wdata`. A byte access may have any alignment. A word access whose address bits [1:0] are not zero is not forwarded: it is answered in the cycle after acceptance with `rsp_misalign`=1, `rsp_miss` showing the window result, and `rsp_rdata` all ones.
- R7: Only one request is outstanding. `req_ready` is 0 from the cycle after a forwarded request is accepted until the cycle of its response. While `bus_done` is 0, `bus_valid` and all bus request fields stay unchanged.
- R8: In the cycle after `bus_done` is seen with `bus_valid`, `bus_valid` falls and `rsp_valid` pulses with both fault flags 0. `rsp_rdata` equals `bus_rdata` for a read and zero for a write.
- R9: A configuration write (`cfg_we`=1, `cfg_sel` picking the register) affects only requests accepted in later cycles. A request accepted in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: base/match register, 1: mask/ignore register |
| cfg_wdata | input | 32 | Configuration write value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Incoming firmware-space address |
| req_size | input | 1 | 0 byte, 1 word |
| req_write | input | 1 | 1 for write |
| req_wdata | input | 32 | Write data |
| bus_valid | output | 1 | Bus request pending |
| bus_addr | output | 32 | Remapped bus address |
| bus_size | output | 1 | Access size toward the bus |
| bus_write | output | 1 | Bus write flag |
| bus_wdata | output | 32 | Bus write data |
| bus_done | input | 1 | Bus completes the pending request |
| bus_rdata | input | 32 | Bus read data, valid with bus_done |
| rsp_valid | output | 1 | Response pulse |
| rsp_miss | output | 1 | Request missed the window |
| rsp_misalign | output | 1 | Word request was not aligned |
| rsp_rdata | output | 32 | Read data, all ones on a fault |

## Verification
The bench targets the window edges: the first and last addresses of each mapped range, and addresses that differ from the match value only in one compared bit. A decoder that ignored the ignore mask, or compared the wrong half of the address, would then forward these addresses or drop them. A partly masked substitution case catches a swapped base/pass-through selection, because it produces a bus address that is neither the base nor the original. A configuration write in the same cycle as an accepted request shows whether new settings leak into that request. A misaligned word access and a misaligned byte access check that the alignment rule applies to words only. A design that cleared `req_ready` too late, or changed the bus fields while waiting, would accept a second request or present a changing address during the stall.

// File: rtl/fwr_pkg.sv
// Shared types for the firmware window remapper.
// Assumes a 1-bit size code: 0 means a byte access, 1 means a full data word.
package fwr_pkg;

    typedef enum logic {
        FWR_SZ_BYTE = 1'b0,
        FWR_SZ_WORD = 1'b1
    } fwr_size_e;

    typedef enum logic {
        FWR_ST_IDLE = 1'b0,
        FWR_ST_WAIT = 1'b1
    } fwr_state_e;

endpackage

// File: rtl/fwr_cfg_bank.sv
// Two packed configuration registers for the window.
// Register 0 holds {substitution base, match value}.
// Register 1 holds {substitution mask, ignore mask}.
// Assumes the address is split into two equal halves; only the upper half is configured.
module fwr_cfg_bank #(
    parameter int ADDR_W = 32,
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [HALF_W-1:0] win_base,
    output logic [HALF_W-1:0] win_match,
    output logic [HALF_W-1:0] win_smask,
    output logic [HALF_W-1:0] win_ignore
);

    logic [ADDR_W-1:0] map_q;
    logic [ADDR_W-1:0] mask_q;

    // Update the selected register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) begin
                mask_q <= wr_data;
            end else begin
                map_q <= wr_data;
            end
        end
    end

    // Split the packed registers into their fields.
    always_comb begin
        win_base   = map_q[ADDR_W-1:HALF_W];
        win_match  = map_q[HALF_W-1:0];
        win_smask  = mask_q[ADDR_W-1:HALF_W];
        win_ignore = mask_q[HALF_W-1:0];
    end

endmodule

// File: rtl/fwr_window.sv
// Combinational window decode and upper-half address substitution.
// Decides the hit from the upper address half, builds the outgoing address,
// and flags word accesses that are not aligned to the data word.
// Assumes DATA_W is a power-of-two number of bytes.
module fwr_window #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int HALF_W = ADDR_W / 2,
    localparam int WORD_BYTES = DATA_W / 8,
    localparam int ALIGN_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
    input  logic              in_size,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [HALF_W-1:0] win_base,
    input  logic [HALF_W-1:0] win_match,
    input  logic [HALF_W-1:0] win_smask,
    input  logic [HALF_W-1:0] win_ignore,
    output logic              hit,
    output logic              aligned,
    output logic [ADDR_W-1:0] out_addr
);

    import fwr_pkg::*;

    logic [HALF_W-1:0] bit_ok;
    logic [HALF_W-1:0] hi_new;

    // Per-bit comparison and substitution over the upper half.
    for (genvar b = 0; b < HALF_W; b++) begin : g_bit
        assign bit_ok[b] = win_ignore[b] | (in_addr[HALF_W+b] == win_match[b]);
        assign hi_new[b] = win_smask[b] ? win_base[b] : in_addr[HALF_W+b];
    end

    // Combine the per-bit results into the hit, alignment and address.
    always_comb begin
        hit      = &bit_ok;
        aligned  = (fwr_size_e'(in_size) == FWR_SZ_BYTE) || (in_addr[ALIGN_W-1:0] == '0);
        out_addr = {hi_new, in_addr[HALF_W-1:0]};
    end

endmodule

// File: rtl/fwr_xact_ctrl.sv
// Single-outstanding request sequencer.
// Accepts a request when idle. It either launches one bus beat or answers
// a fault at once. It waits for bus completion, then sends one response pulse.
// Assumes bus_done is only raised while bus_valid is high.
module fwr_xact_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              dec_hit,
    input  logic              dec_aligned,
    input  logic [ADDR_W-1:0] dec_addr,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_size,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic              rsp_misalign,
    output logic [DATA_W-1:0] rsp_rdata
);

    import fwr_pkg::*;

    fwr_state_e state_q;
    logic       accept;
    logic       forward;

    // Handshake and forwarding decision for the current cycle.
    always_comb begin
        req_ready = (state_q == FWR_ST_IDLE);
        accept    = req_valid && req_ready;
        forward   = dec_hit && dec_aligned;
    end

    // Sequence acceptance, the bus beat and the response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= FWR_ST_IDLE;
            bus_valid    <= 1'b0;
            bus_addr     <= '0;
            bus_size     <= 1'b0;
            bus_write    <= 1'b0;
            bus_wdata    <= '0;
            rsp_valid    <= 1'b0;
            rsp_miss     <= 1'b0;
            rsp_misalign <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                FWR_ST_IDLE: begin
                    if (accept) begin
                        if (forward) begin
                            bus_valid <= 1'b1;
                            bus_addr  <= dec_addr;
                            bus_size  <= req_size;
                            bus_write <= req_write;
                            bus_wdata <= req_wdata;
                            state_q   <= FWR_ST_WAIT;
                        end else begin
                            rsp_valid    <= 1'b1;
                            rsp_miss     <= !dec_hit;
                            rsp_misalign <= !dec_aligned;
                            rsp_rdata    <= '1;
                        end
                    end
                end
                FWR_ST_WAIT: begin
                    if (bus_done) begin
                        bus_valid    <= 1'b0;
                        state_q      <= FWR_ST_IDLE;
                        rsp_valid    <= 1'b1;
                        rsp_miss     <= 1'b0;
                        rsp_misalign <= 1'b0;
                        rsp_rdata    <= bus_write ? '0 : bus_rdata;
                    end
                end
                default: state_q <= FWR_ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lpc_fw_remap.sv
// Top of the firmware window remapper.
// Ties the configuration bank, the window decoder and the request sequencer.
// The decoder sees the registered configuration, so a write takes effect
// only for requests accepted after it.
module lpc_fw_remap #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_size,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic              rsp_misalign,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [HALF_W-1:0] win_base;
    logic [HALF_W-1:0] win_match;
    logic [HALF_W-1:0] win_smask;
    logic [HALF_W-1:0] win_ignore;
    logic              dec_hit;
    logic              dec_aligned;
    logic [ADDR_W-1:0] dec_addr;

    fwr_cfg_bank #(.ADDR_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_sel     (cfg_sel),
        .wr_data    (cfg_wdata),
        .win_base   (win_base),
        .win_match  (win_match),
        .win_smask  (win_smask),
        .win_ignore (win_ignore)
    );

    fwr_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_win (
        .in_size    (req_size),
        .in_addr    (req_addr),
        .win_base   (win_base),
        .win_match  (win_match),
        .win_smask  (win_smask),
        .win_ignore (win_ignore),
        .hit        (dec_hit),
        .aligned    (dec_aligned),
        .out_addr   (dec_addr)
    );

    fwr_xact_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_size     (req_size),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .dec_hit      (dec_hit),
        .dec_aligned  (dec_aligned),
        .dec_addr     (dec_addr),
        .bus_valid    (bus_valid),
        .bus_addr     (bus_addr),
        .bus_size     (bus_size),
        .bus_write    (bus_write),
        .bus_wdata    (bus_wdata),
        .bus_done     (bus_done),
        .bus_rdata    (bus_rdata),
        .rsp_valid    (rsp_valid),
        .rsp_miss     (rsp_miss),
        .rsp_misalign (rsp_misalign),
        .rsp_rdata    (rsp_rdata)
    );

endmodule

// File: rtl/fwr_chk.sv
// Protocol checker for the firmware window remapper, bound to the top.
// Observes only top-level ports.
module fwr_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int WORD_BYTES = DATA_W / 8,
    localparam int ALIGN_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_size,
    input logic              bus_write,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_done,
    input logic              rsp_valid,
    input logic              rsp_miss,
    input logic              rsp_misalign,
    input logic [DATA_W-1:0] rsp_rdata
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (req_ready && !bus_valid && !rsp_valid));

    // R7
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);

    // R7
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_addr) && $stable(bus_size)
                                      && $stable(bus_write) && $stable(bus_wdata)));

    // R5
    fault_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_miss || rsp_misalign)) |-> (rsp_rdata == '1));

    // R5
    miss_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> !bus_valid);

    // R8
    done_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_done) |=> (rsp_valid && !rsp_miss && !rsp_misalign && !bus_valid));

    // R6
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_size) |-> (bus_addr[ALIGN_W-1:0] == '0));

endmodule

bind lpc_fw_remap fwr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .bus_valid    (bus_valid),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .bus_write    (bus_write),
    .bus_wdata    (bus_wdata),
    .bus_done     (bus_done),
    .rsp_valid    (rsp_valid),
    .rsp_miss     (rsp_miss),
    .rsp_misalign (rsp_misalign),
    .rsp_rdata    (rsp_rdata)
);

// File: tb/sim_lpc_fw_remap.sv
module sim_lpc_fw_remap;

    typedef struct packed {
        logic [31:0] cfg_a;
        logic [31:0] cfg_b;
        logic [31:0] addr;
        logic        size;
        logic        wr;
        logic [31:0] wdata;
        logic        fwd;
        logic [31:0] baddr;
        logic [31:0] brd;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{32'h3000FCE0, 32'hFFE0001F, 32'hFCE00000, 1'b1, 1'b0, 32'h0,        1'b1, 32'h30000000, 32'hDEADBEEF},
        '{32'h3000FCE0, 32'hFFE0001F, 32'hFCFFFFFC, 1'b1, 1'b1, 32'h11223344, 1'b1, 32'h301FFFFC, 32'h0},
        '{32'h3000FCE0, 32'hFFE0001F, 32'hFD000000, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0,        32'h0},
        '{32'h3000FCE0, 32'hFFE0001F, 32'hFCC00010, 1'b0, 1'b1, 32'h000000AA, 1'b0, 32'h0,        32'h0},
        '{32'h30000E00, 32'hFE0001FF, 32'h0E000003, 1'b0, 1'b1, 32'h0000005A, 1'b1, 32'h30000003, 32'h0},
        '{32'h30000E00, 32'hFE0001FF, 32'h0FFFFFF0, 1'b1, 1'b0, 32'h0,        1'b1, 32'h31FFFFF0, 32'hCAFEF00D},
        '{32'h30000E00, 32'hFE0001FF, 32'h10000000, 1'b1, 1'b0, 32'h0,        1'b0, 32'h0,        32'h0},
        '{32'hA5A51234, 32'h0F0F0000, 32'h12345678, 1'b0, 1'b0, 32'h0,        1'b1, 32'h15355678, 32'h000000C3},
        '{32'hA5A51234, 32'h0F0F0000, 32'h12355678, 1'b1, 1'b0, 32'h0,        1'b0, 32'h0,        32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_size = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic        bus_size;
    logic        bus_write;
    logic [31:0] bus_wdata;
    logic        bus_done = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        rsp_valid;
    logic        rsp_miss;
    logic        rsp_misalign;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lpc_fw_remap u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_rdata(bus_rdata),
        .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_misalign(rsp_misalign),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request and check the bus beat and the response.
    task automatic run_req(input logic [31:0] addr, input logic size, input logic wr,
                           input logic [31:0] wdata, input logic fwd,
                           input logic [31:0] baddr, input logic [31:0] brd,
                           input logic exp_miss, input logic exp_misal, input string tag);
        @(negedge clk);
        chk({tag, " R7 ready before accept"}, {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_addr = addr; req_size = size; req_write = wr; req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        if (fwd) begin
            chk({tag, " R2 forwarded"}, {31'b0, bus_valid}, 32'd1);
            chk({tag, " R3 R4 bus address"}, bus_addr, baddr);
            chk({tag, " R6 size/write"}, {30'b0, bus_size, bus_write}, {30'b0, size, wr});
            if (wr) chk({tag, " R6 write data"}, bus_wdata, wdata);
            chk({tag, " R7 ready low"}, {31'b0, req_ready}, 32'd0);
            @(negedge clk);
            chk({tag, " R7 held"}, {bus_addr[30:0], bus_valid}, {baddr[30:0], 1'b1});
            chk({tag, " R7 ready still low"}, {31'b0, req_ready}, 32'd0);
            bus_done = 1'b1; bus_rdata = brd;
            @(negedge clk);
            bus_done = 1'b0; bus_rdata = '0;
            chk({tag, " R8 response"}, {29'b0, rsp_valid, rsp_miss, rsp_misalign}, 32'd4);
            chk({tag, " R8 data"}, rsp_rdata, wr ? 32'h0 : brd);
            chk({tag, " R8 bus released"}, {30'b0, bus_valid, req_ready}, 32'd1);
        end else begin
            chk({tag, " R5 R6 not forwarded"}, {31'b0, bus_valid}, 32'd0);
            chk({tag, " R5 R6 fault flags"}, {29'b0, rsp_valid, rsp_miss, rsp_misalign},
                {29'b0, 1'b1, exp_miss, exp_misal});
            chk({tag, " R5 fault data"}, rsp_rdata, 32'hFFFFFFFF);
        end
        @(negedge clk);
        chk({tag, " R8 single pulse"}, {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle outputs after reset
        chk("R1 reset outputs", {29'b0, req_ready, bus_valid, rsp_valid}, 32'd4);
        // R1 zero configuration: exact match on 0x0000 with no substitution
        run_req(32'h00001234, 1'b0, 1'b0, 32'h0, 1'b1, 32'h00001234, 32'h00000077, 1'b0, 1'b0, "R1 zero cfg hit");
        run_req(32'h00011234, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b1, 1'b0, "R1 zero cfg miss");

        // R9 write in the same cycle as acceptance uses the old value
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h00000001;
        req_valid = 1'b1; req_addr = 32'h00010000; req_size = 1'b0; req_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk("R9 same-cycle write uses old cfg", {30'b0, rsp_valid, rsp_miss}, 32'd3);
        run_req(32'h00010000, 1'b0, 1'b0, 32'h0, 1'b1, 32'h00010000, 32'h00000011, 1'b0, 1'b0, "R9 later request sees new cfg");

        // Table-driven window cases (R2 R3 R4 R5 R6)
        for (int i = 0; i < NVEC; i++) begin
            write_cfg(1'b0, VECS[i].cfg_a);
            write_cfg(1'b1, VECS[i].cfg_b);
            run_req(VECS[i].addr, VECS[i].size, VECS[i].wr, VECS[i].wdata, VECS[i].fwd,
                    VECS[i].baddr, VECS[i].brd, !VECS[i].fwd, 1'b0, $sformatf("vec%0d", i));
        end

        // R6 misaligned word inside the window is rejected
        write_cfg(1'b0, 32'h3000FCE0);
        write_cfg(1'b1, 32'hFFE0001F);
        run_req(32'hFCE00002, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, "R6 misaligned word");
        // R6 misaligned word outside the window raises both flags
        run_req(32'h00000001, 1'b1, 1'b1, 32'h5, 1'b0, 32'h0, 32'h0, 1'b1, 1'b1, "R6 misaligned word miss");
        // R6 misaligned byte is forwarded
        run_req(32'hFCE00001, 1'b0, 1'b0, 32'h0, 1'b1, 32'h30000001, 32'h000000E5, 1'b0, 1'b0, "R6 byte any alignment");

        finished = 1'b1;
        report();
    end

endmodule